// File: doc/BRIEF.md
# Video Crop Window Generator

This block marks a rectangular region inside each video field. It watches the pixel clock domain's sync pulses and pixel strobe from a decoder front end. It raises three flags: one for lines that fall inside the window, one for pixels that fall inside the window, and a combined crop-valid flag that qualifies individual pixels. Downstream capture or scaling logic keeps only the pixels that carry crop-valid.

The window has four 10-bit settings: the line offset after the vertical sync edge, the number of window lines, the pixel offset after the horizontal sync edge, and the number of window pixels. A byte-wide register port holds them. Each setting keeps its low byte in its own register, and the upper two bits of all four settings share one packed register. Some low bytes are banked by video standard. The same index reaches a different copy depending on the standard currently selected. The copies in use are captured at every vertical sync edge, so a change made mid-field applies from the next field on.

Top module: `crop_window_gen`

## Requirements
- R1: Register indices are 0 (line offset low byte), 1 (line count low byte), 2 (pixel offset low byte), 3 (pixel count low byte) and 4 (upper bits, packed as line offset [7:6], line count [5:4], pixel offset [3:2], pixel count [1:0]). Indices 5 to 7 read as 0x00, and writes to them change no register.
- R2: After reset, indices 0 to 4 read 0x12, 0xF0, 0x0F, 0xD0 and 0x02. Every banked copy resets to the same value as its main copy.
- R3: The standard input codes are 0 = 60 Hz, 1 = PAL (50 Hz), 2 = SECAM (50 Hz) and 3 = treated as 60 Hz. Index 1 reads and writes the 50 Hz copy of the line count low byte while code 1 or 2 is selected, and the main copy otherwise.
- R4: Index 2 reads and writes the PAL copy of the pixel offset low byte under code 1, the SECAM copy under code 2, and the main copy under code 0 or 3.
- R5: The captured line count uses the 50 Hz copy when a 50 Hz code is selected and the hold input is low. It uses the main copy when the code is 60 Hz or the hold input is high. The captured pixel offset uses the copy that matches the selected code.
- R6: The line index is the number of horizontal sync leading edges since the last vertical sync leading edge. The line flag is high while offset <= index < offset + count.
- R7: The pixel index is the number of pixel strobes since the last horizontal sync leading edge. The pixel flag is high while offset <= index < offset + count.
- R8: Crop-valid is high only in a cycle where the pixel strobe is high and both flags are high. It is low in any cycle that holds a sync leading edge, and a strobe in such a cycle is not counted.
- R9: Settings are captured only on a vertical sync leading edge. A write during a field leaves that field's window unchanged and applies from the next field.
- R10: A line count or pixel count of zero keeps crop-valid low for the whole field.
- R11: From reset until the first vertical sync leading edge, the line flag and crop-valid stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | Vertical sync, rising edge starts a field |
| hsync | input | 1 | Horizontal sync, rising edge starts a line |
| pixValid | input | 1 | Pixel strobe |
| stdSel | input | 2 | Video standard code (R3) |
| vact50Hold | input | 1 | When high, 50 Hz fields use the main line count copy |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr, combinational |
| lineActive | output | 1 | Current line is inside the window |
| pixActive | output | 1 | Current pixel index is inside the window |
| cropValid | output | 1 | Current pixel strobe is inside the window |

## Verification
The bench probes the window edges: a zero line offset that makes the partial line before the first horizontal sync count as index 0, windows that run past the last line or pixel of the field, and zero counts. A design with an off-by-one in either compare would gain or lose a full row or column. The bench also interleaves idle cycles between pixel strobes, to catch a design that counts clock cycles instead of strobes. Banking is checked by writing the same index under every standard and reading each copy back; a design that ignores the bank would return the last value written for every standard. Mid-field writes and standard changes are checked against the field already in progress. A design that uses live register values would shift the window in the middle of a field.

// File: rtl/crop_win_pkg.sv
package crop_win_pkg;
  localparam int WIN_W  = 10;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    STD_60HZ = 2'd0,
    STD_PAL  = 2'd1,
    STD_SECAM = 2'd2,
    STD_ALT  = 2'd3
  } vidStd_e;

  // strobes from sync control to the counting datapath
  typedef struct packed {
    logic frameStart;
    logic lineStart;
    logic pixStep;
  } syncStrobe_t;

  typedef struct packed {
    logic [WIN_W-1:0] vDelay;
    logic [WIN_W-1:0] vActive;
    logic [WIN_W-1:0] hDelay;
    logic [WIN_W-1:0] hActive;
  } winCfg_t;
endpackage

// File: rtl/crop_win_regs.sv
module crop_win_regs
  import crop_win_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter logic [BYTE_W-1:0] RST_VDLY = 8'h12,
  parameter logic [BYTE_W-1:0] RST_VACT = 8'hF0,
  parameter logic [BYTE_W-1:0] RST_HDLY = 8'h0F,
  parameter logic [BYTE_W-1:0] RST_HACT = 8'hD0,
  parameter logic [BYTE_W-1:0] RST_HI   = 8'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [1:0]        stdSel,
  input  logic              vact50Hold,
  output logic [BYTE_W-1:0] rdData,
  output winCfg_t           cfg
);
  localparam int HI_W = WIN_W - BYTE_W;
  localparam int HI_HACT_LSB = 0;
  localparam int HI_HDLY_LSB = HI_W;
  localparam int HI_VACT_LSB = 2 * HI_W;
  localparam int HI_VDLY_LSB = 3 * HI_W;
  localparam int N_VACT_BANK = 2;
  localparam int N_HDLY_BANK = 3;
  localparam int HDLY_SEL_W  = $clog2(N_HDLY_BANK);
  localparam logic [ADDR_W-1:0] A_VDLY = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_VACT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_HDLY = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_HACT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(4);

  logic [BYTE_W-1:0] vDlyLo, hActLo, hiReg;
  logic [N_VACT_BANK-1:0][BYTE_W-1:0] vActBank;
  logic [N_HDLY_BANK-1:0][BYTE_W-1:0] hDlyBank;
  logic [N_VACT_BANK-1:0] vActWe;
  logic [N_HDLY_BANK-1:0] hDlyWe;

  vidStd_e std;
  logic is50;
  logic vActAccess;
  logic vActUse;
  logic [HDLY_SEL_W-1:0] hDlySel;

  assign std        = vidStd_e'(stdSel);
  assign is50       = (std == STD_PAL) || (std == STD_SECAM);
  assign vActAccess = is50;
  assign vActUse    = is50 && !vact50Hold;

  always_comb begin
    case (std)
      STD_PAL:   hDlySel = HDLY_SEL_W'(1);
      STD_SECAM: hDlySel = HDLY_SEL_W'(2);
      default:   hDlySel = '0;
    endcase
  end

  always_comb begin
    vActWe = '0;
    hDlyWe = '0;
    if (wrEn && addr == A_VACT) vActWe[vActAccess] = 1'b1;
    if (wrEn && addr == A_HDLY) hDlyWe[hDlySel]    = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vDlyLo <= RST_VDLY;
      hActLo <= RST_HACT;
      hiReg  <= RST_HI;
      for (int b = 0; b < N_VACT_BANK; b++) vActBank[b] <= RST_VACT;
      for (int b = 0; b < N_HDLY_BANK; b++) hDlyBank[b] <= RST_HDLY;
    end else begin
      if (wrEn && addr == A_VDLY) vDlyLo <= wrData;
      if (wrEn && addr == A_HACT) hActLo <= wrData;
      if (wrEn && addr == A_HI)   hiReg  <= wrData;
      for (int b = 0; b < N_VACT_BANK; b++)
        if (vActWe[b]) vActBank[b] <= wrData;
      for (int b = 0; b < N_HDLY_BANK; b++)
        if (hDlyWe[b]) hDlyBank[b] <= wrData;
    end
  end

  always_comb begin
    case (addr)
      A_VDLY:  rdData = vDlyLo;
      A_VACT:  rdData = vActBank[vActAccess];
      A_HDLY:  rdData = hDlyBank[hDlySel];
      A_HACT:  rdData = hActLo;
      A_HI:    rdData = hiReg;
      default: rdData = '0;
    endcase
  end

  assign cfg.vDelay  = {hiReg[HI_VDLY_LSB +: HI_W], vDlyLo};
  assign cfg.vActive = {hiReg[HI_VACT_LSB +: HI_W], vActBank[vActUse]};
  assign cfg.hDelay  = {hiReg[HI_HDLY_LSB +: HI_W], hDlyBank[hDlySel]};
  assign cfg.hActive = {hiReg[HI_HACT_LSB +: HI_W], hActLo};

  p_unused_idx_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr > A_HI) |=> ($stable(vDlyLo) && $stable(hActLo) && $stable(hiReg)
                               && $stable(vActBank) && $stable(hDlyBank)));

  p_vact_bank_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_VACT && is50) |=> (vActBank[1] == $past(wrData) && $stable(vActBank[0])));

  p_hdly_pal_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_HDLY && std == STD_PAL)
      |=> (hDlyBank[1] == $past(wrData) && $stable(hDlyBank[0]) && $stable(hDlyBank[2])));
endmodule

// File: rtl/crop_win_ctrl.sv
module crop_win_ctrl
  import crop_win_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        vsync,
  input  logic        hsync,
  input  logic        pixValid,
  output syncStrobe_t strb
);
  logic vsPrev, hsPrev;

  // previous levels reset high so a sync held high through reset is not an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vsPrev <= 1'b1;
      hsPrev <= 1'b1;
    end else begin
      vsPrev <= vsync;
      hsPrev <= hsync;
    end
  end

  assign strb.frameStart = vsync && !vsPrev;
  assign strb.lineStart  = hsync && !hsPrev;
  assign strb.pixStep    = pixValid && !strb.frameStart && !strb.lineStart;

  p_single_frame_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameStart |=> !strb.frameStart);

  p_single_line_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.lineStart |=> !strb.lineStart);
endmodule

// File: rtl/crop_win_datapath.sv
module crop_win_datapath
  import crop_win_pkg::*;
#(
  parameter int CNT_W = WIN_W + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  syncStrobe_t strb,
  input  winCfg_t     cfg,
  output logic        lineActive,
  output logic        pixActive,
  output logic        cropValid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  winCfg_t work;
  logic [CNT_W-1:0] lineCnt, pixCnt;
  logic [CNT_W-1:0] vStart, vEnd, hStart, hEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      work    <= '0;
      lineCnt <= CNT_MAX;
    end else if (strb.frameStart) begin
      work    <= cfg;
      lineCnt <= '0;
    end else if (strb.lineStart && lineCnt != CNT_MAX) begin
      lineCnt <= lineCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                pixCnt <= CNT_MAX;
    else if (strb.lineStart)                  pixCnt <= '0;
    else if (strb.pixStep && pixCnt != CNT_MAX) pixCnt <= pixCnt + 1'b1;
  end

  assign vStart = CNT_W'(work.vDelay);
  assign vEnd   = CNT_W'(work.vDelay) + CNT_W'(work.vActive);
  assign hStart = CNT_W'(work.hDelay);
  assign hEnd   = CNT_W'(work.hDelay) + CNT_W'(work.hActive);

  assign lineActive = (lineCnt >= vStart) && (lineCnt < vEnd);
  assign pixActive  = (pixCnt >= hStart) && (pixCnt < hEnd);
  assign cropValid  = lineActive && pixActive && strb.pixStep;

  p_zero_window_r10: assert property (@(posedge clk) disable iff (!rstN)
    (work.vActive == '0 || work.hActive == '0) |-> !cropValid);

  p_hold_cfg_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.frameStart |=> $stable(work));

  p_frame_clears_line_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameStart |=> (lineCnt == '0));

  p_pix_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lineStart && !strb.frameStart) |=> (pixCnt == '0));
endmodule

// File: rtl/crop_window_gen.sv
module crop_window_gen
  import crop_win_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vsync,
  input  logic              hsync,
  input  logic              pixValid,
  input  logic [1:0]        stdSel,
  input  logic              vact50Hold,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              lineActive,
  output logic              pixActive,
  output logic              cropValid
);
  syncStrobe_t strb;
  winCfg_t     cfg;

  crop_win_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData),
    .stdSel(stdSel), .vact50Hold(vact50Hold), .rdData(regRdData), .cfg(cfg)
  );

  crop_win_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .vsync(vsync), .hsync(hsync), .pixValid(pixValid), .strb(strb)
  );

  crop_win_datapath i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg),
    .lineActive(lineActive), .pixActive(pixActive), .cropValid(cropValid)
  );

  logic seenFrame;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               seenFrame <= 1'b0;
    else if (strb.frameStart) seenFrame <= 1'b1;
  end

  p_idle_before_frame_r11: assert property (@(posedge clk) disable iff (!rstN)
    !seenFrame |-> (!lineActive && !cropValid));

  p_crop_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    cropValid |-> pixValid);
endmodule

// File: tb/test_crop_window_gen.sv
`timescale 1ns/1ps
module test_crop_window_gen;
  localparam int LINES  = 8;
  localparam int PIXELS = 12;
  localparam int N_VEC  = 7;

  typedef struct packed {
    logic [9:0]  vd;
    logic [9:0]  va;
    logic [9:0]  hd;
    logic [9:0]  ha;
    logic        gap;
    logic [11:0] expTot;
  } winVec_t;

  // window settings, strobe pattern, expected crop-valid total over LINES x PIXELS
  localparam winVec_t VECS [N_VEC] = '{
    '{10'd1, 10'd3,   10'd2,  10'd5,   1'b0, 12'd15},
    '{10'd0, 10'd8,   10'd0,  10'd12,  1'b1, 12'd84},
    '{10'd5, 10'd0,   10'd1,  10'd4,   1'b0, 12'd0},
    '{10'd2, 10'd4,   10'd0,  10'd0,   1'b1, 12'd0},
    '{10'd6, 10'd10,  10'd10, 10'd5,   1'b0, 12'd6},
    '{10'd1, 10'd1,   10'd11, 10'd1,   1'b1, 12'd1},
    '{10'd2, 10'd256, 10'd3,  10'd256, 1'b0, 12'd63}
  };

  logic clk = 1'b0;
  logic rstN, vsync, hsync, pixValid, vact50Hold, regWrEn;
  logic [1:0] stdSel;
  logic [2:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic lineActive, pixActive, cropValid;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  crop_window_gen i_crop_window_gen (
    .clk(clk), .rstN(rstN), .vsync(vsync), .hsync(hsync), .pixValid(pixValid),
    .stdSel(stdSel), .vact50Hold(vact50Hold), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .lineActive(lineActive),
    .pixActive(pixActive), .cropValid(cropValid)
  );

  task automatic checkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic h, input logic p);
    @(negedge clk);
    vsync = v; hsync = h; pixValid = p;
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic doVsync();
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
  endtask

  task automatic runLines(input int vd, input int va, input int hd, input int ha,
                          input bit gap, output int total, output int mism);
    int mLine, mPix;
    bit eL, eP, eC;
    total = 0; mism = 0; mLine = 0;
    for (int l = 0; l < LINES; l++) begin
      cyc(1'b0, 1'b1, 1'b0);
      mLine++; mPix = 0;
      cyc(1'b0, 1'b0, 1'b0);
      if (cropValid !== 1'b0) mism++;
      for (int j = 0; j < PIXELS; j++) begin
        if (gap) begin
          cyc(1'b0, 1'b0, 1'b0);
          if (cropValid !== 1'b0) mism++;
        end
        cyc(1'b0, 1'b0, 1'b1);
        eL = (mLine >= vd) && (mLine < vd + va);
        eP = (mPix >= hd) && (mPix < hd + ha);
        eC = eL && eP;
        if (lineActive !== eL || pixActive !== eP || cropValid !== eC) mism++;
        if (cropValid === 1'b1) total++;
        mPix++;
      end
    end
    cyc(1'b0, 1'b0, 1'b0);
  endtask

  task automatic frameCheck(input string tag, input int vd, input int va, input int hd,
                            input int ha, input bit gap, input int expTotal);
    int total, mism;
    doVsync();
    runLines(vd, va, hd, ha, gap, total, mism);
    checkEq({tag, " window total"}, total, expTotal);
    checkEq({tag, " per-pixel flags mismatches"}, mism, 0);
  endtask

  task automatic resetDut();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  task automatic checkDefaults(input string tag);
    logic [7:0] d;
    rd(3'd0, d); checkEq({tag, " R2 index0"}, d, 8'h12);
    rd(3'd1, d); checkEq({tag, " R2 index1"}, d, 8'hF0);
    rd(3'd2, d); checkEq({tag, " R2 index2"}, d, 8'h0F);
    rd(3'd3, d); checkEq({tag, " R2 index3"}, d, 8'hD0);
    rd(3'd4, d); checkEq({tag, " R2 index4"}, d, 8'h02);
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int bad, total, mism;
    vsync = 0; hsync = 0; pixValid = 0; vact50Hold = 0; regWrEn = 0;
    stdSel = 2'd0; regAddr = 0; regWrData = 0;
    resetDut();

    // reset state of outputs and registers
    checkEq("R11 reset lineActive", lineActive, 0);
    checkEq("R11 reset pixActive", pixActive, 0);
    checkEq("R11 reset cropValid", cropValid, 0);
    checkDefaults("first");

    // R11: lines and pixels before any vertical sync edge
    bad = 0;
    for (int l = 0; l < 20; l++) begin
      cyc(1'b0, 1'b1, 1'b0);
      for (int j = 0; j < PIXELS; j++) begin
        cyc(1'b0, 1'b0, 1'b1);
        if (cropValid !== 1'b0 || lineActive !== 1'b0) bad++;
      end
    end
    cyc(1'b0, 1'b0, 1'b0);
    checkEq("R11 no flags before first field", bad, 0);

    // R3 and R4: banked copies per standard
    stdSel = 2'd1; wr(3'd1, 8'h05); wr(3'd2, 8'h01);
    stdSel = 2'd2; wr(3'd2, 8'h0A);
    stdSel = 2'd1; rd(3'd1, d); checkEq("R3 PAL line count copy", d, 8'h05);
    rd(3'd2, d); checkEq("R4 PAL pixel offset copy", d, 8'h01);
    stdSel = 2'd2; rd(3'd1, d); checkEq("R3 SECAM line count copy", d, 8'h05);
    rd(3'd2, d); checkEq("R4 SECAM pixel offset copy", d, 8'h0A);
    stdSel = 2'd0; rd(3'd1, d); checkEq("R3 60Hz line count main", d, 8'hF0);
    rd(3'd2, d); checkEq("R4 60Hz pixel offset main", d, 8'h0F);
    stdSel = 2'd3; rd(3'd1, d); checkEq("R3 code3 line count main", d, 8'hF0);
    rd(3'd2, d); checkEq("R4 code3 pixel offset main", d, 8'h0F);

    // main copies: offset 1, count 2, pixel offset 0, pixel count 3
    stdSel = 2'd0;
    wr(3'd0, 8'd1); wr(3'd1, 8'd2); wr(3'd2, 8'd0); wr(3'd3, 8'd3); wr(3'd4, 8'h00);

    // R1: unused indices
    wr(3'd5, 8'hFF); wr(3'd7, 8'hAA);
    rd(3'd5, d); checkEq("R1 index5 reads zero", d, 0);
    rd(3'd6, d); checkEq("R1 index6 reads zero", d, 0);
    rd(3'd7, d); checkEq("R1 index7 reads zero", d, 0);
    rd(3'd0, d); checkEq("R1 index0 untouched by unused writes", d, 1);
    rd(3'd3, d); checkEq("R1 index3 untouched by unused writes", d, 3);
    rd(3'd4, d); checkEq("R1 index4 untouched by unused writes", d, 0);

    // R5: selection of copies captured per standard
    stdSel = 2'd1; vact50Hold = 0;
    frameCheck("R5 PAL 50Hz copy", 1, 5, 1, 3, 1'b0, 15);
    vact50Hold = 1;
    frameCheck("R5 PAL hold uses main count", 1, 2, 1, 3, 1'b0, 6);
    stdSel = 2'd2; vact50Hold = 0;
    frameCheck("R5 SECAM copies", 1, 5, 10, 3, 1'b1, 10);
    stdSel = 2'd0;
    frameCheck("R5 60Hz main copies", 1, 2, 0, 3, 1'b0, 6);

    // R9: mid-field writes and standard change apply next field
    doVsync();
    wr(3'd1, 8'd6); wr(3'd3, 8'd12);
    stdSel = 2'd1;
    runLines(1, 2, 0, 3, 1'b0, total, mism);
    checkEq("R9 current field keeps old window", total, 6);
    checkEq("R9 current field flags", mism, 0);
    stdSel = 2'd0;
    frameCheck("R9 next field uses new window", 1, 6, 0, 12, 1'b0, 72);

    // R6 R7 R8 R10: table of windows
    for (int i = 0; i < N_VEC; i++) begin
      wr(3'd0, VECS[i].vd[7:0]);
      wr(3'd1, VECS[i].va[7:0]);
      wr(3'd2, VECS[i].hd[7:0]);
      wr(3'd3, VECS[i].ha[7:0]);
      wr(3'd4, {VECS[i].vd[9:8], VECS[i].va[9:8], VECS[i].hd[9:8], VECS[i].ha[9:8]});
      rd(3'd4, d);
      checkEq($sformatf("R1 packed upper bits vec%0d", i), d,
              {VECS[i].vd[9:8], VECS[i].va[9:8], VECS[i].hd[9:8], VECS[i].ha[9:8]});
      frameCheck($sformatf("R6 R7 R8 R10 vec%0d", i), VECS[i].vd, VECS[i].va,
                 VECS[i].hd, VECS[i].ha, VECS[i].gap, VECS[i].expTot);
    end

    // R8: strobe coinciding with a line sync edge is dropped
    wr(3'd0, 8'd0); wr(3'd1, 8'd8); wr(3'd2, 8'd0); wr(3'd3, 8'd12); wr(3'd4, 8'h00);
    doVsync();
    cyc(1'b0, 1'b1, 1'b1);
    checkEq("R8 crop low on line sync edge", cropValid, 0);
    cyc(1'b0, 1'b0, 1'b1);
    checkEq("R8 edge strobe not counted, pixel index 0 valid", cropValid, 1);
    cyc(1'b0, 1'b0, 1'b0);
    checkEq("R8 crop low without strobe", cropValid, 0);

    // R2: second reset restores defaults and clears flags
    resetDut();
    checkEq("R11 second reset cropValid", cropValid, 0);
    checkEq("R11 second reset lineActive", lineActive, 0);
    checkDefaults("second");
    stdSel = 2'd1; rd(3'd1, d); checkEq("R2 50Hz copy reset", d, 8'hF0);
    rd(3'd2, d); checkEq("R2 PAL copy reset", d, 8'h0F);
    stdSel = 2'd2; rd(3'd2, d); checkEq("R2 SECAM copy reset", d, 8'h0F);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule